// File: doc/BRIEF.md
# Hardware-Software Event Bridge

This block passes discrete events between hardware logic and a processor through a small register port. When a hardware producer raises its event line, the bridge records the event in a pending bit and keeps the value that came with it. Software finds it either by polling the pending bits or, for events in interrupt mode, through a per-event interrupt request. Software retires an event by writing a one to its bit in the acknowledge register. In the other direction, software first loads an outgoing value and then raises that event's flag bit. The bridge turns the flag's rising edge into a single-cycle strobe and presents the stored value to the hardware consumer alongside it.

A set of environment inputs is also reduced to single-cycle strobes. This lets a stimulus that is held for many cycles count as one event. Event lines and strobes are plain wires with no handshake. A strobe lasts exactly one cycle and cannot be stalled, so no valid/ready back-pressure exists on either side, and a consumer that is not listening loses the strobe. The bus side is a write strobe with address and data, plus a read-data output that decodes the address combinationally.

Top module: `event_bridge`

## Requirements
- R1: After reset, every pending bit, mode bit, flag bit and stored value reads 0. The irq_o, s2h_ev_o and env_ev_o outputs are all 0.
- R2: A 0-to-1 transition on hw_ev_in[i] sets pending bit i and stores the hw_val_in lane i that was present in the first high cycle. Pending bits are read at address 0 with bit i for event i. Stored values are read zero-extended at address 8+i. Both are visible by the second clock edge after the first high sample.
- R3: An input held high for several cycles counts as exactly one event. On env_in[j], env_ev_o[j] goes high for one cycle, one edge after the first high sample. On hw_ev_in[i], an acknowledge written while the line is still high is not undone by that same high level.
- R4: A bus write to address 1 clears pending bit i for each data bit i that is 1. Bits written as 0 leave their events pending.
- R5: A new event on an already pending slot replaces the stored value and leaves the bit set. When an event and an acknowledge of the same slot reach the same clock edge, the event wins.
- R6: Address 2 holds one mode bit per event, with 1 selecting interrupt mode. irq_o[i] is high exactly while event i is pending and its mode bit is 1, so it holds until acknowledged. Polled events never raise irq_o.
- R7: Address 12+i holds the outgoing value of lane i, and address 3 holds the outgoing flag bits. A write that takes flag bit i from 0 to 1 makes s2h_ev_o[i] high for exactly one cycle, two clock edges after the write edge. During that cycle s2h_val_o lane i carries the last value written.
- R8: Writing 1 to a flag bit that is already 1, or writing 0 to a flag bit, produces no strobe.
- R9: Writes to the pending register and to the stored-value addresses have no effect. Reads from unmapped addresses 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| hw_ev_in | input | NUM_EV | Hardware event lines, rising edge counts |
| hw_val_in | input | NUM_EV*VAL_W | Value lanes that accompany hw_ev_in |
| irq_o | output | NUM_EV | Per-event interrupt request |
| s2h_ev_o | output | NUM_EV | One-cycle software-to-hardware strobes |
| s2h_val_o | output | NUM_EV*VAL_W | Outgoing value lanes |
| env_in | input | NUM_ENV | Environment stimulus lines of any length |
| env_ev_o | output | NUM_ENV | One-cycle strobes from env_in |

## Verification
The bench holds event lines high across several cycles and acknowledges a slot while its line is still high. A level-sensitive design would fire again or re-set the pending bit, and the bench would see a second strobe or a stale pending bit. It drives an acknowledge onto the same edge as a fresh event, where a design that lets the clear win would lose the event. It rewrites a flag that is already set and clears a flag, where a design that fires on any write or on either edge would add strobes to the counted total. It also checks that a polled event never raises its interrupt, that an interrupt holds through idle cycles, and that the value presented during a strobe is the one most recently written, so a design that captured an earlier or later value would fail.

// File: rtl/evb_pkg.sv
package evb_pkg;
  // upper two address bits select a region
  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_RSVD = 2'd1,
    RG_HVAL = 2'd2,
    RG_SVAL = 2'd3
  } region_e;

  // word offsets inside the control region
  typedef enum logic [1:0] {
    CT_STAT = 2'd0,
    CT_ACK  = 2'd1,
    CT_MODE = 2'd2,
    CT_FLAG = 2'd3
  } ctrl_e;
endpackage

// File: rtl/evb_edge.sv
// Registered rising-edge detector: one-cycle strobe per 0->1 transition.
module evb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      rise_o <= lvl_i & ~prev_q;
    end
  end
endmodule

// File: rtl/evb_h2s_slot.sv
// One hardware-to-software event: pending bit, stored value, mode, irq.
module evb_h2s_slot #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_in,
  input  logic [VAL_W-1:0] val_in,
  input  logic             ack,
  input  logic             mode_we,
  input  logic             mode_d,
  output logic             status_o,
  output logic [VAL_W-1:0] value_o,
  output logic             mode_o,
  output logic             irq_o
);
  logic             hit;
  logic [VAL_W-1:0] val_pipe;

  evb_edge u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (ev_in),
    .rise_o(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_pipe <= '0;
      status_o <= 1'b0;
      value_o  <= '0;
      mode_o   <= 1'b0;
    end else begin
      val_pipe <= val_in;            // aligned with the registered strobe
      if (hit) begin
        status_o <= 1'b1;            // a new event beats a same-edge ack
        value_o  <= val_pipe;
      end else if (ack) begin
        status_o <= 1'b0;
      end
      if (mode_we) mode_o <= mode_d;
    end
  end

  assign irq_o = status_o & mode_o;
endmodule

// File: rtl/evb_s2h_slot.sv
// One software-to-hardware event: value register, flag, flag-edge strobe.
module evb_s2h_slot #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_we,
  input  logic             flag_d,
  input  logic             val_we,
  input  logic [VAL_W-1:0] val_d,
  output logic             flag_o,
  output logic [VAL_W-1:0] val_o,
  output logic             ev_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      val_o  <= '0;
    end else begin
      if (flag_we) flag_o <= flag_d;
      if (val_we)  val_o  <= val_d;
    end
  end

  evb_edge u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (flag_o),
    .rise_o(ev_o)
  );
endmodule

// File: rtl/event_bridge.sv
module event_bridge
  import evb_pkg::*;
#(
  parameter int NUM_EV  = 4,
  parameter int NUM_ENV = 2,
  parameter int VAL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NUM_EV-1:0]       hw_ev_in,
  input  logic [NUM_EV*VAL_W-1:0] hw_val_in,
  output logic [NUM_EV-1:0]       irq_o,
  output logic [NUM_EV-1:0]       s2h_ev_o,
  output logic [NUM_EV*VAL_W-1:0] s2h_val_o,
  input  logic [NUM_ENV-1:0]      env_in,
  output logic [NUM_ENV-1:0]      env_ev_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             wr_ctrl, wr_ack, wr_mode, wr_flag;
  logic [NUM_EV-1:0] stat_vec, mode_vec, flag_vec, wr_sval;
  logic [VAL_W-1:0] hval [NUM_EV];
  logic             unused_wdata;

  assign region  = bus_addr[ADDR_W-1 -: 2];
  assign idx     = bus_addr[IDX_W-1:0];
  assign wr_ctrl = bus_wr && (region == RG_CTRL);
  assign wr_ack  = wr_ctrl && (idx == IDX_W'(CT_ACK));
  assign wr_mode = wr_ctrl && (idx == IDX_W'(CT_MODE));
  assign wr_flag = wr_ctrl && (idx == IDX_W'(CT_FLAG));
  assign unused_wdata = ^bus_wdata;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    assign wr_sval[g] = bus_wr && (region == RG_SVAL) && (idx == IDX_W'(g));

    evb_h2s_slot #(.VAL_W(VAL_W)) u_h2s (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_in   (hw_ev_in[g]),
      .val_in  (hw_val_in[g*VAL_W +: VAL_W]),
      .ack     (wr_ack && bus_wdata[g]),
      .mode_we (wr_mode),
      .mode_d  (bus_wdata[g]),
      .status_o(stat_vec[g]),
      .value_o (hval[g]),
      .mode_o  (mode_vec[g]),
      .irq_o   (irq_o[g])
    );

    evb_s2h_slot #(.VAL_W(VAL_W)) u_s2h (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_we(wr_flag),
      .flag_d (bus_wdata[g]),
      .val_we (wr_sval[g]),
      .val_d  (bus_wdata[VAL_W-1:0]),
      .flag_o (flag_vec[g]),
      .val_o  (s2h_val_o[g*VAL_W +: VAL_W]),
      .ev_o   (s2h_ev_o[g])
    );
  end

  for (genvar e = 0; e < NUM_ENV; e++) begin : g_env
    evb_edge u_env (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (env_in[e]),
      .rise_o(env_ev_o[e])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (region)
      RG_CTRL: begin
        if (idx == IDX_W'(CT_STAT)) bus_rdata = DATA_W'(stat_vec);
        if (idx == IDX_W'(CT_MODE)) bus_rdata = DATA_W'(mode_vec);
        if (idx == IDX_W'(CT_FLAG)) bus_rdata = DATA_W'(flag_vec);
      end
      RG_HVAL: begin
        for (int i = 0; i < NUM_EV; i++)
          if (idx == IDX_W'(i)) bus_rdata = DATA_W'(hval[i]);
      end
      RG_SVAL: begin
        for (int i = 0; i < NUM_EV; i++)
          if (idx == IDX_W'(i)) bus_rdata = DATA_W'(s2h_val_o[i*VAL_W +: VAL_W]);
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evb_checker.sv
module evb_checker
  import evb_pkg::*;
#(
  parameter int NUM_EV  = 4,
  parameter int NUM_ENV = 2,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [NUM_EV-1:0]  irq_o,
  input logic [NUM_EV-1:0]  s2h_ev_o,
  input logic [NUM_ENV-1:0] env_in,
  input logic [NUM_ENV-1:0] env_ev_o
);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(CT_ACK);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(CT_MODE);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(CT_FLAG);

  // an interrupt only drops after an acknowledge or mode write
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_o) & ~irq_o) != '0) |->
      ($past(bus_wr) && ($past(bus_addr) == A_ACK || $past(bus_addr) == A_MODE)));

  // a strobe toward hardware follows a flag write two edges earlier
  p_s2h_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2h_ev_o != '0) |-> ($past(bus_wr, 2) && $past(bus_addr, 2) == A_FLAG));

  p_s2h_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2h_ev_o & $past(s2h_ev_o)) == '0);

  p_env_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (env_ev_o & $past(env_ev_o)) == '0);

  p_env_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (env_ev_o & ~$past(env_in)) == '0);
endmodule

bind event_bridge evb_checker #(
  .NUM_EV (NUM_EV),
  .NUM_ENV(NUM_ENV),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_addr(bus_addr),
  .bus_wr  (bus_wr),
  .irq_o   (irq_o),
  .s2h_ev_o(s2h_ev_o),
  .env_in  (env_in),
  .env_ev_o(env_ev_o)
);

// File: tb/event_bridge_test.sv
`timescale 1ns/1ps
module event_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  hw_ev_in = '0;
  logic [31:0] hw_val_in = '0;
  logic [3:0]  irq_o, s2h_ev_o;
  logic [31:0] s2h_val_o;
  logic [1:0]  env_in = '0;
  logic [1:0]  env_ev_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int s2h_cnt = 0;
  logic [7:0] s2h_seen = '0;
  int env_cnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  event_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_ev_in(hw_ev_in),
    .hw_val_in(hw_val_in), .irq_o(irq_o), .s2h_ev_o(s2h_ev_o),
    .s2h_val_o(s2h_val_o), .env_in(env_in), .env_ev_o(env_ev_o)
  );

  // strobe monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (s2h_ev_o[0]) begin
        s2h_cnt++;
        s2h_seen = s2h_val_o[7:0];
      end
      if (env_ev_o[1]) env_cnt++;
    end
  end

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read-compare, 2 hw event on lane addr
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [0:20] = '{
    '{2'd1, 4'd0,  32'h0,  4'd1},  // R1 nothing pending after reset
    '{2'd2, 4'd0,  32'h5A, 4'd2},  // R2 event lane 0
    '{2'd1, 4'd0,  32'h1,  4'd2},
    '{2'd1, 4'd8,  32'h5A, 4'd2},
    '{2'd2, 4'd2,  32'h33, 4'd2},  // R2 event lane 2
    '{2'd1, 4'd0,  32'h5,  4'd2},
    '{2'd1, 4'd10, 32'h33, 4'd2},
    '{2'd0, 4'd0,  32'hF,  4'd9},  // R9 write to pending reg ignored
    '{2'd1, 4'd0,  32'h5,  4'd9},
    '{2'd0, 4'd1,  32'h1,  4'd4},  // R4 ack lane 0 only
    '{2'd1, 4'd0,  32'h4,  4'd4},
    '{2'd2, 4'd2,  32'h77, 4'd5},  // R5 overwrite while pending
    '{2'd1, 4'd0,  32'h4,  4'd5},
    '{2'd1, 4'd10, 32'h77, 4'd5},
    '{2'd0, 4'd2,  32'h2,  4'd6},  // R6 lane 1 to interrupt mode
    '{2'd1, 4'd2,  32'h2,  4'd6},
    '{2'd0, 4'd12, 32'hC3, 4'd7},  // R7 outgoing value lane 0
    '{2'd1, 4'd12, 32'hC3, 4'd7},
    '{2'd1, 4'd5,  32'h0,  4'd9},  // R9 unmapped read
    '{2'd0, 4'd1,  32'h4,  4'd4},
    '{2'd1, 4'd0,  32'h0,  4'd4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic hw_event(input int lane, input logic [7:0] v);
    @(negedge clk);
    hw_ev_in[lane] = 1'b1;
    hw_val_in[lane*8 +: 8] = v;
    repeat (3) @(negedge clk);
    hw_ev_in[lane] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(4'd2, rd);  check("R1 mode", rd, 32'h0);
    bus_read(4'd3, rd);  check("R1 flag", rd, 32'h0);
    bus_read(4'd12, rd); check("R1 sval", rd, 32'h0);
    check("R1 outputs", {irq_o, s2h_ev_o, env_ev_o}, 32'h0);

    for (int n = 0; n <= 20; n++) begin
      case (TBL[n].op)
        2'd0: bus_write(TBL[n].addr, TBL[n].data);
        2'd1: begin
          bus_read(TBL[n].addr, rd);
          checks++;
          if (rd !== TBL[n].data) begin
            errors++;
            $display("FAIL R%0d row %0d actual=0x%0h expected=0x%0h",
                     TBL[n].req, n, rd, TBL[n].data);
          end
        end
        default: hw_event(int'(TBL[n].addr), TBL[n].data[7:0]);
      endcase
    end

    // R6 interrupt lane holds until acknowledged
    hw_event(1, 8'h44);
    check("R6 irq raised", 32'(irq_o), 32'h2);
    repeat (5) @(negedge clk);
    check("R6 irq held", 32'(irq_o), 32'h2);
    bus_write(4'd1, 32'h2);
    check("R6 irq cleared", 32'(irq_o), 32'h0);

    // R6 polled lane raises no interrupt
    hw_event(3, 8'h09);
    check("R6 polled no irq", 32'(irq_o), 32'h0);
    bus_read(4'd0, rd); check("R6 polled pending", rd, 32'h8);
    bus_write(4'd1, 32'h8);

    // R7 flag rise gives one strobe with value
    s2h_cnt = 0;
    bus_write(4'd3, 32'h1);
    repeat (4) @(negedge clk);
    check("R7 strobe count", 32'(s2h_cnt), 32'd1);
    check("R7 strobe value", 32'(s2h_seen), 32'hC3);

    // R8 rewrite of a set flag and a clear give nothing
    bus_write(4'd3, 32'h1);
    repeat (4) @(negedge clk);
    check("R8 rewrite set flag", 32'(s2h_cnt), 32'd1);
    bus_write(4'd3, 32'h0);
    repeat (4) @(negedge clk);
    check("R8 falling flag", 32'(s2h_cnt), 32'd1);

    // R7 second handoff carries the new value
    bus_write(4'd12, 32'h5E);
    bus_write(4'd3, 32'h1);
    repeat (4) @(negedge clk);
    check("R7 second strobe", 32'(s2h_cnt), 32'd2);
    check("R7 second value", 32'(s2h_seen), 32'h5E);

    // R3 long environment pulse is one strobe
    env_cnt = 0;
    @(negedge clk); env_in[1] = 1'b1;
    repeat (6) @(negedge clk); env_in[1] = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 env single", 32'(env_cnt), 32'd1);

    // R3 long hw pulse acked while still high stays cleared
    @(negedge clk); hw_ev_in[0] = 1'b1; hw_val_in[7:0] = 8'h21;
    repeat (3) @(negedge clk);
    bus_write(4'd1, 32'h1);
    repeat (4) @(negedge clk);
    hw_ev_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(4'd0, rd); check("R3 hw single", rd, 32'h0);

    // R5 event and ack on the same edge: event wins
    @(negedge clk); hw_ev_in[0] = 1'b1; hw_val_in[7:0] = 8'h11;
    @(negedge clk); bus_addr = 4'd1; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; hw_ev_in[0] = 1'b0;
    bus_read(4'd0, rd); check("R5 collision pending", rd, 32'h1);
    bus_read(4'd8, rd); check("R5 collision value", rd, 32'h11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule